// File: doc/BRIEF.md
# Dual-Width One-Time-Programmable Memory Port

This block is a synthesizable behavioural model of a one-time-programmable read-only array of 16-bit words. Reads are served either as full words or as single bytes. A width-select input picks the organisation. In byte organisation a low-order address input, which stands in for the pin that doubles as the top data bit, chooses the lower or the upper half of the addressed word. Two active-low controls gate the outputs. Chip enable selects the device, and while it is high the block sits in standby with every output released. Output enable gates data onto the bus once the device is selected.

An identification input stands in for the raised-voltage strobe on an address pin. While it is asserted, reads return fixed codes instead of array contents. A program cycle needs four things at once: the program-voltage flag high, output enable high, chip enable low and the program strobe high. In that cycle the array ANDs the data-in word into the addressed location. The array starts erased (all ones), so a bit can only ever move from 1 to 0. Read results are registered and appear one clock after the inputs are sampled. That clock latency stands in for the access time. Each output bit has its own output-enable line, so a pad ring can build tri-state drivers from the pair.

Top module: `otp_rom_port`

## Requirements
- R1: While rst_ni is low, rdata_oe_o and rdata_o are all zeros.
- R2: When ce_ni=0, oe_ni=0, word_mode_i=1 and id_mode_i=0 are sampled at a clock edge, then after that edge rdata_o holds the word stored at addr_i and rdata_oe_o equals 16'hFFFF.
- R3: When ce_ni=0, oe_ni=0, word_mode_i=0 and id_mode_i=0 are sampled, then after that edge rdata_o[7:0] holds bits [7:0] of the addressed word if addr_lsb_i=0, or bits [15:8] if addr_lsb_i=1. rdata_o[15:8] is 0 and rdata_oe_o equals 16'h00FF. In this mode bit 15 is undriven because it serves as an address input.
- R4: When ce_ni=0 and oe_ni=1 are sampled, rdata_oe_o is all zeros and rdata_o is all zeros after that edge.
- R5: When ce_ni=1 is sampled, rdata_oe_o and rdata_o are all zeros after that edge, whatever the other inputs are.
- R6: A read with id_mode_i=1 returns 8'h20 on rdata_o[7:0] when addr_i[0]=0 and 8'h32 when addr_i[0]=1, with rdata_o[15:8]=0. The array contents and addr_lsb_i have no effect. rdata_oe_o follows word_mode_i as in R2 and R3.
- R7: After reset every array location reads 16'hFFFF.
- R8: A clock edge that samples vpp_ok_i=1, ce_ni=0, oe_ni=1 and pgm_i=1 replaces the word at addr_i with its bitwise AND with wdata_i.
- R9: A program cycle never changes a stored 0 bit to 1. Programming a cleared location with 16'hFFFF leaves it unchanged.
- R10: No array location changes if ce_ni=1, vpp_ok_i=0, oe_ni=0 or pgm_i=0 is sampled. With vpp_ok_i=1 and ce_ni=1, the outputs are released as in R5.
- R11: Every result depends only on the inputs sampled at the immediately preceding edge. Back-to-back reads of different addresses or modes each produce their own result one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Word address |
| addr_lsb_i | input | 1 | Byte-half select in byte organisation (the dual-role bit) |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| word_mode_i | input | 1 | 1 selects word organisation, 0 selects byte organisation |
| id_mode_i | input | 1 | Identification read select |
| vpp_ok_i | input | 1 | Program voltage present |
| pgm_i | input | 1 | Program strobe |
| wdata_i | input | 16 | Data to program |
| rdata_o | output | 16 | Registered read data, zero where not enabled |
| rdata_oe_o | output | 16 | Per-bit output enable |

## Verification
A corrupted array word shows up at the ports on the first read of that address. A word read exposes all sixteen bits one cycle later. A byte read exposes only the selected half, so both halves are read back separately. A wrong program decode is harder to spot: a write that should have been inhibited, or that ORs instead of ANDs, stays hidden until that location is read again. Because of this, every inhibit case and every re-program case is followed directly by a readback. A wrong enable or width decode appears on rdata_oe_o in the very next cycle, and every cycle's output is compared against a reference model.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] MFR_CODE = 8'h20;
  localparam logic [BYTE_W-1:0] DEV_CODE = 8'h32;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic [WORD_W-1:0] oe;
  } rd_beat_t;
endpackage

// File: rtl/otp_array.sv
module otp_array
  import otp_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  // erased state is all ones; programming can only clear bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (wr_en_i) begin
      mem_q[addr_i] <= mem_q[addr_i] & wr_data_i;
    end
  end

  assign rd_data_o = mem_q[addr_i];

  p_and_merge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem_q[$past(addr_i)] == ($past(rd_data_o) & $past(wr_data_i)));

  p_clear_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (mem_q[$past(addr_i)] & ~$past(rd_data_o)) == '0);
endmodule

// File: rtl/otp_read_sel.sv
module otp_read_sel
  import otp_pkg::*;
(
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              word_mode_i,
  input  logic              byte_hi_i,
  input  logic              id_mode_i,
  input  logic              id_sel_i,
  input  logic [WORD_W-1:0] rd_word_i,
  output rd_beat_t          beat_o
);
  logic [WORD_W-1:0] src_word;
  logic [BYTE_W-1:0] src_byte;
  logic              drive;

  assign drive = !ce_ni && !oe_ni;

  always_comb begin
    if (id_mode_i) begin
      src_word = {{(WORD_W-BYTE_W){1'b0}}, (id_sel_i ? DEV_CODE : MFR_CODE)};
      src_byte = src_word[BYTE_W-1:0];
    end else begin
      src_word = rd_word_i;
      src_byte = byte_hi_i ? rd_word_i[WORD_W-1:BYTE_W] : rd_word_i[BYTE_W-1:0];
    end
  end

  always_comb begin
    beat_o = '0;
    if (drive) begin
      if (word_mode_i) begin
        beat_o.data = src_word;
        beat_o.oe   = '1;
      end else begin
        beat_o.data = {{(WORD_W-BYTE_W){1'b0}}, src_byte};
        beat_o.oe   = {{(WORD_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
      end
    end
  end
endmodule

// File: rtl/otp_out_stage.sv
module otp_out_stage
  import otp_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  rd_beat_t beat_i,
  output rd_beat_t beat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) beat_o <= '0;
    else         beat_o <= beat_i;
  end

  p_quiet_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_o.data & ~beat_o.oe) == '0);
endmodule

// File: rtl/otp_rom_port.sv
module otp_rom_port
  import otp_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              addr_lsb_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              word_mode_i,
  input  logic              id_mode_i,
  input  logic              vpp_ok_i,
  input  logic              pgm_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [WORD_W-1:0] rdata_oe_o
);
  logic              wr_en;
  logic [WORD_W-1:0] rd_word;
  rd_beat_t          beat_d, beat_q;
  logic              past_ok_q;

  assign wr_en = vpp_ok_i && !ce_ni && oe_ni && pgm_i;

  otp_array #(.ADDR_W(ADDR_W)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .addr_i    (addr_i),
    .wr_data_i (wdata_i),
    .rd_data_o (rd_word)
  );

  otp_read_sel u_sel (
    .ce_ni       (ce_ni),
    .oe_ni       (oe_ni),
    .word_mode_i (word_mode_i),
    .byte_hi_i   (addr_lsb_i),
    .id_mode_i   (id_mode_i),
    .id_sel_i    (addr_i[0]),
    .rd_word_i   (rd_word),
    .beat_o      (beat_d)
  );

  otp_out_stage u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .beat_i (beat_d),
    .beat_o (beat_q)
  );

  assign rdata_o    = beat_q.data;
  assign rdata_oe_o = beat_q.oe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> rdata_oe_o == '0);

  p_standby_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && $past(ce_ni) |-> rdata_oe_o == '0);

  p_disable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && $past(oe_ni) |-> rdata_oe_o == '0);

  p_word_oe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && $past(!ce_ni && !oe_ni && word_mode_i) |-> rdata_oe_o == '1);

  p_byte_hiz_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && $past(!word_mode_i) |-> rdata_oe_o[WORD_W-1:BYTE_W] == '0);

  p_sig_mfr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && $past(!ce_ni && !oe_ni && id_mode_i && !addr_i[0])
    |-> rdata_o == {{(WORD_W-BYTE_W){1'b0}}, MFR_CODE});

  p_sig_dev_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && $past(!ce_ni && !oe_ni && id_mode_i && addr_i[0])
    |-> rdata_o == {{(WORD_W-BYTE_W){1'b0}}, DEV_CODE});
endmodule

// File: tb/otp_rom_port_tb_top.sv
module otp_rom_port_tb_top;
  localparam int unsigned AW = 8;
  localparam int unsigned DEPTH = 1 << AW;

  typedef struct {
    logic [15:0] d;
    logic [15:0] oe;
    string       req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic lsb = 1'b0, ce_n = 1'b1, oe_n = 1'b1, wm = 1'b1, idm = 1'b0, vpp = 1'b0, pgm = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, rdata_oe;

  logic [15:0] ref_mem [DEPTH];
  exp_t sb_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  otp_rom_port #(.ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .addr_lsb_i(lsb),
    .ce_ni(ce_n), .oe_ni(oe_n), .word_mode_i(wm), .id_mode_i(idm),
    .vpp_ok_i(vpp), .pgm_i(pgm), .wdata_i(wdata),
    .rdata_o(rdata), .rdata_oe_o(rdata_oe)
  );

  task automatic check(input logic [15:0] ad, input logic [15:0] aoe,
                       input logic [15:0] ed, input logic [15:0] eoe, input string req);
    n_chk++;
    if (ad !== ed || aoe !== eoe) begin
      n_fail++;
      $display("FAIL %s: data=%h oe=%h expected data=%h oe=%h", req, ad, aoe, ed, eoe);
    end
  endtask

  // driver: one cycle of stimulus, pushes the expected result
  task automatic cyc(input logic c_n, input logic o_n, input logic w, input logic id,
                     input logic v, input logic p, input logic [AW-1:0] a,
                     input logic l, input logic [15:0] din, input string req);
    exp_t e;
    logic [15:0] src;
    @(negedge clk);
    ce_n = c_n; oe_n = o_n; wm = w; idm = id; vpp = v; pgm = p;
    addr = a; lsb = l; wdata = din;
    e.req = req; e.d = '0; e.oe = '0;
    if (!c_n && !o_n) begin
      if (id) src = {8'h00, (a[0] ? 8'h32 : 8'h20)};
      else    src = ref_mem[a];
      if (w) begin
        e.d = src; e.oe = 16'hFFFF;
      end else begin
        e.d = {8'h00, (id ? src[7:0] : (l ? src[15:8] : src[7:0]))};
        e.oe = 16'h00FF;
      end
    end
    if (v && !c_n && o_n && p) ref_mem[a] = ref_mem[a] & din;
    sb_q.push_back(e);
  endtask

  task automatic rd_word(input logic [AW-1:0] a, input string req);
    cyc(0, 0, 1, 0, 0, 0, a, 0, 16'h0, req);
  endtask
  task automatic rd_byte(input logic [AW-1:0] a, input logic l, input string req);
    cyc(0, 0, 0, 0, 0, 0, a, l, 16'h0, req);
  endtask
  task automatic prog(input logic [AW-1:0] a, input logic [15:0] d, input string req);
    cyc(0, 1, 1, 0, 1, 1, a, 0, d, req);
  endtask

  // monitor: samples 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(rdata, rdata_oe, e.d, e.oe, e.req);
      end
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 16'hFFFF;
    repeat (3) @(posedge clk);
    #2;
    check(rdata, rdata_oe, 16'h0, 16'h0, "R1 reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R7 erased contents
    rd_word(0, "R7 erased");
    rd_word(8'd255, "R7 erased");
    rd_byte(8'd17, 1, "R7 erased byte");

    // R8 programming and readback, R2 word reads, R3 byte halves
    prog(3, 16'hA5C3, "R8 prog");
    prog(0, 16'h1234, "R8 prog");
    prog(8'd255, 16'h0F0F, "R8 prog");
    rd_word(3, "R2 word");
    rd_word(0, "R2 word");
    rd_word(8'd255, "R2 word");
    rd_byte(3, 0, "R3 byte lo");
    rd_byte(3, 1, "R3 byte hi");
    rd_byte(0, 1, "R3 byte hi");
    rd_byte(0, 0, "R3 byte lo");

    // R9 re-program cannot restore ones
    prog(3, 16'hFFFF, "R9 reprog ones");
    rd_word(3, "R9 unchanged");
    prog(3, 16'hF0FF, "R9 clear more");
    rd_word(3, "R9 and result");

    // R10 inhibit cases, each followed by readback
    cyc(1, 1, 1, 0, 1, 1, 0, 0, 16'h0000, "R10 inhibit ce high");
    rd_word(0, "R10 after ce high");
    cyc(0, 1, 1, 0, 0, 1, 0, 0, 16'h0000, "R10 inhibit no vpp");
    rd_word(0, "R10 after no vpp");
    cyc(0, 0, 1, 0, 1, 1, 0, 0, 16'h0000, "R10 inhibit oe low");
    rd_word(0, "R10 after oe low");
    cyc(0, 1, 1, 0, 1, 0, 0, 0, 16'h0000, "R10 inhibit no strobe");
    rd_word(0, "R10 after no strobe");

    // R4 output disable, R5 standby
    cyc(0, 1, 1, 0, 0, 0, 3, 0, 16'h0, "R4 disable word");
    cyc(0, 1, 0, 1, 0, 0, 1, 1, 16'h0, "R4 disable id");
    cyc(1, 0, 1, 0, 0, 0, 3, 0, 16'h0, "R5 standby oe low");
    cyc(1, 0, 0, 1, 0, 0, 0, 1, 16'h0, "R5 standby byte id");

    // R6 signature reads in both widths
    cyc(0, 0, 1, 1, 0, 0, 8'd2, 0, 16'h0, "R6 mfr word");
    cyc(0, 0, 1, 1, 0, 0, 8'd3, 1, 16'h0, "R6 dev word");
    cyc(0, 0, 0, 1, 0, 0, 8'd4, 1, 16'h0, "R6 mfr byte");
    cyc(0, 0, 0, 1, 0, 0, 8'd255, 0, 16'h0, "R6 dev byte");

    // R11 sweep: program every location, then mixed back-to-back reads
    for (int i = 0; i < DEPTH; i++)
      prog(i[AW-1:0], 16'(i * 16'h9E37) ^ 16'h5AA5, "R8 sweep prog");
    for (int i = 0; i < DEPTH; i++) begin
      case (i % 4)
        0: rd_word(i[AW-1:0], "R11 sweep word");
        1: rd_byte(i[AW-1:0], 1'b0, "R11 sweep lo");
        2: rd_byte(i[AW-1:0], 1'b1, "R11 sweep hi");
        default: cyc(0, 0, 1, 1, 0, 0, i[AW-1:0], 0, 16'h0, "R11 sweep id");
      endcase
    end
    for (int i = 0; i < DEPTH; i++)
      prog(i[AW-1:0], 16'hFFFF ^ 16'(1 << (i % 16)), "R9 sweep clear");
    for (int i = 0; i < DEPTH; i++) rd_word(i[AW-1:0], "R9 sweep read");

    cyc(1, 1, 1, 0, 0, 0, 0, 0, 16'h0, "R5 idle");
    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R11: %0d results not produced, expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule